// File: doc/BRIEF.md
# PCI Power Management Control/Status Register

This block holds the 16-bit power management control/status word of a PCI function that runs as a satellite endpoint. The host reads and writes it through configuration cycles with two byte enables. The word holds a wake-status flag, a wake-enable bit and a two-bit device power state. A local processor raises wake events through a request strobe. It sees the effects of host writes as three sticky event flags in its own status view, and each flag has an interrupt line that the local side can mask.

Host writes do more than update fields. Clearing wake status, setting wake enable and changing the power state each latch a sticky flag for the local CPU. Host writes that ask for one of the two reserved power states are dropped. The active-low wake output follows the AND of wake enable and wake status.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After a synchronous active-low reset, the host word reads 0x0000, the power state is D0 (00), all three local flags and interrupt enables are 0, `wake_n` is 1 and every interrupt output is 0.
- R2: Only the configuration address `CSR_OFFSET` (default 0xE0) decodes the register. Bits 14:9 and 7:2 always read 0 and ignore writes. A read or write at any other address returns 0 and changes nothing.
- R3: Byte enable bit 0 gates host writes to bits 7:0 and bit 1 gates host writes to bits 15:8. With a byte enable low, that byte is left as it was.
- R4: The power state field (bits 1:0) accepts host writes of 00 (D0) and 11 (D3hot). Writes of 01 or 10 are ignored and the field keeps its value.
- R5: Wake status (bit 15) is set to 1 one cycle after `loc_wake_req` is high. A host write of 1 to bit 15 clears it, and a host write of 0 leaves it as it was.
- R6: When a host clear and `loc_wake_req` fall in the same cycle, wake status ends up 1 and no wake-cleared flag is latched.
- R7: `wake_n` is 0 exactly while wake enable (bit 8) and wake status are both 1.
- R8: Local flag bit 1 (enable-set) is latched when a host write takes wake enable from 0 to 1. A write of 1 while the bit is already 1 does not latch it.
- R9: Local flag bit 2 (state-change) is latched when an accepted host write gives the power state a new value. A write of the same value does not latch it.
- R10: Local flag bit 0 (wake-cleared) is latched when a host write clears wake status that was 1.
- R11: A 1 in bit i of `loc_flag_clr` clears local flag i. If flag i is set in the same cycle, the set wins.
- R12: Each interrupt output equals its flag ANDed with the matching bit of the local interrupt-enable register. That register is loaded from `loc_ie_wdata` when `loc_ie_wr` is high. Interrupts are ordered wake-cleared (bit 0), enable-set (bit 1), state-change (bit 2).
- R13: `loc_pstate` always shows the current power state field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Host configuration write strobe |
| cfg_addr | input | ADDR_W | Host configuration address for reads and writes |
| cfg_be | input | 2 | Host byte enables |
| cfg_wdata | input | 16 | Host write data |
| cfg_rdata | output | 16 | Host read data (combinational) |
| loc_wake_req | input | 1 | Local request that sets wake status |
| loc_flag_clr | input | 3 | Local write-one-to-clear of the sticky flags |
| loc_ie_wr | input | 1 | Load strobe for the local interrupt-enable register |
| loc_ie_wdata | input | 3 | New local interrupt-enable value |
| loc_flags | output | 3 | Sticky flags: wake-cleared, enable-set, state-change |
| loc_pstate | output | 2 | Mirror of the power state field |
| wake_n | output | 1 | Active-low wake output |
| irq_wake_clr | output | 1 | Wake-cleared interrupt |
| irq_en_set | output | 1 | Enable-set interrupt |
| irq_ps_chg | output | 1 | State-change interrupt |

## Verification
The hardest situations to reach are the same-cycle collisions: a host clear of wake status against a local wake request, and a local flag clear against a host write that sets the same flag. The stimulus first drives wake status or the flag into a known state. It then presents both strobes at the same falling edge, so they are seen together on one rising edge. The bench then reads back the host word and the local flags to confirm that the set won. Reserved power-state writes, redundant writes and writes at a foreign address are each followed at once by a read to confirm that nothing moved.

// File: rtl/pm_csr_pkg.sv
// Shared constants and types for the power management register block.
// Assumes a 16-bit register with fixed field positions.
package pm_csr_pkg;

    localparam int CSR_W    = 16;
    localparam int BE_W     = CSR_W / 8;
    localparam int STS_BIT  = 15;
    localparam int EN_BIT   = 8;
    localparam int PS_W     = 2;

    localparam int NUM_EVT   = 3;
    localparam int EVT_WCLR  = 0;
    localparam int EVT_ENSET = 1;
    localparam int EVT_PSCHG = 2;

    typedef enum logic [PS_W-1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_e;

    // Only D0 and D3hot are accepted from the host.
    function automatic logic ps_is_legal(logic [PS_W-1:0] v);
        return (v == PS_D0) || (v == PS_D3HOT);
    endfunction

endpackage

// File: rtl/pm_host_fields.sv
// Host-visible fields of the power management word: wake status (W1C,
// set locally), wake enable (R/W) and power state (R/W, reserved values
// dropped). Produces one-cycle event pulses for the local flag block.
// Assumes cfg_wr is a single-cycle strobe. Reads are combinational.
module pm_host_fields
    import pm_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CSR_OFFSET = 'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [CSR_W-1:0]  cfg_wdata,
    output logic [CSR_W-1:0]  cfg_rdata,
    input  logic              loc_wake_req,
    output logic              wake_sts,
    output logic              wake_en,
    output logic [PS_W-1:0]   pstate,
    output logic [NUM_EVT-1:0] evt_set
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(CSR_OFFSET);
    localparam int HI_BYTE = STS_BIT / 8;
    localparam int EN_BYTE = EN_BIT / 8;

    logic            hit;
    logic            wr_sts_byte;
    logic            wr_en_byte;
    logic            wr_ps_byte;
    logic            clr_req;
    logic [PS_W-1:0] ps_wdata;
    logic            ps_accept;

    // Decode which fields this write touches.
    always_comb begin
        hit         = (cfg_addr == OFFS);
        wr_sts_byte = cfg_wr && hit && cfg_be[HI_BYTE];
        wr_en_byte  = cfg_wr && hit && cfg_be[EN_BYTE];
        wr_ps_byte  = cfg_wr && hit && cfg_be[0];
        clr_req     = wr_sts_byte && cfg_wdata[STS_BIT];
        ps_wdata    = cfg_wdata[PS_W-1:0];
        ps_accept   = wr_ps_byte && ps_is_legal(ps_wdata);
    end

    // Wake status: local set beats host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_sts <= 1'b0;
        else if (loc_wake_req)
            wake_sts <= 1'b1;
        else if (clr_req)
            wake_sts <= 1'b0;
    end

    // Wake enable: plain host read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_en <= 1'b0;
        else if (wr_en_byte)
            wake_en <= cfg_wdata[EN_BIT];
    end

    // Power state: only legal encodings are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pstate <= PS_D0;
        else if (ps_accept)
            pstate <= ps_wdata;
    end

    // Event pulses that feed the local sticky flags.
    always_comb begin
        evt_set            = '0;
        evt_set[EVT_WCLR]  = clr_req && wake_sts && !loc_wake_req;
        evt_set[EVT_ENSET] = wr_en_byte && cfg_wdata[EN_BIT] && !wake_en;
        evt_set[EVT_PSCHG] = ps_accept && (ps_wdata != pstate);
    end

    // Read mux: assembled word at the decoded offset, zero elsewhere.
    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[STS_BIT]    = wake_sts;
            cfg_rdata[EN_BIT]     = wake_en;
            cfg_rdata[PS_W-1:0]   = pstate;
        end
    end

endmodule

// File: rtl/pm_event_flags.sv
// Local sticky event flags with per-flag interrupt enables.
// A set pulse has priority over a local write-one-to-clear in the same
// cycle. Each interrupt is the flag masked by its enable bit.
module pm_event_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         ie_wr,
    input  logic [N-1:0] ie_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);

    logic [N-1:0] ie_q;

    // Interrupt-enable register, loaded by the local side.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= '0;
        else if (ie_wr)
            ie_q <= ie_wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_i[i])
                flags[i] <= 1'b1;
            else if (clr_i[i])
                flags[i] <= 1'b0;
        end
    end

    // Masked interrupt requests.
    always_comb irq = flags & ie_q;

endmodule

// File: rtl/pm_ctrl_reg.sv
// Top of the power management control/status register. It ties the
// host-visible fields to the local sticky flags and drives the
// active-low wake output. Assumes one clock domain for host and local.
module pm_ctrl_reg
    import pm_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CSR_OFFSET = 'hE0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [BE_W-1:0]    cfg_be,
    input  logic [CSR_W-1:0]   cfg_wdata,
    output logic [CSR_W-1:0]   cfg_rdata,
    input  logic               loc_wake_req,
    input  logic [NUM_EVT-1:0] loc_flag_clr,
    input  logic               loc_ie_wr,
    input  logic [NUM_EVT-1:0] loc_ie_wdata,
    output logic [NUM_EVT-1:0] loc_flags,
    output logic [PS_W-1:0]    loc_pstate,
    output logic               wake_n,
    output logic               irq_wake_clr,
    output logic               irq_en_set,
    output logic               irq_ps_chg
);

    logic               wake_sts;
    logic               wake_en;
    logic [PS_W-1:0]    pstate;
    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] irq_vec;

    pm_host_fields #(
        .ADDR_W     (ADDR_W),
        .CSR_OFFSET (CSR_OFFSET)
    ) u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_be       (cfg_be),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .loc_wake_req (loc_wake_req),
        .wake_sts     (wake_sts),
        .wake_en      (wake_en),
        .pstate       (pstate),
        .evt_set      (evt_set)
    );

    pm_event_flags #(
        .N (NUM_EVT)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .clr_i    (loc_flag_clr),
        .ie_wr    (loc_ie_wr),
        .ie_wdata (loc_ie_wdata),
        .flags    (loc_flags),
        .irq      (irq_vec)
    );

    // Output mapping: wake pin, state mirror and named interrupts.
    always_comb begin
        wake_n       = !(wake_en && wake_sts);
        loc_pstate   = pstate;
        irq_wake_clr = irq_vec[EVT_WCLR];
        irq_en_set   = irq_vec[EVT_ENSET];
        irq_ps_chg   = irq_vec[EVT_PSCHG];
    end

endmodule

// File: rtl/pm_ctrl_reg_chk.sv
// Checker for pm_ctrl_reg, attached by bind. Observes ports and the
// internal wake status/enable nets that separate logic drives.
module pm_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        loc_wake_req,
    input logic        wake_sts,
    input logic        wake_en,
    input logic [15:0] cfg_rdata,
    input logic [2:0]  loc_flags,
    input logic [1:0]  loc_pstate,
    input logic        wake_n,
    input logic        irq_wake_clr,
    input logic        irq_en_set,
    input logic        irq_ps_chg
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & 16'h7EFC) == 16'h0000); // R2

    AST_PS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_pstate == 2'b00) || (loc_pstate == 2'b11)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wake_req |=> wake_sts); // R6

    AST_WAKE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |-> (wake_en && wake_sts)); // R7

    AST_PS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loc_pstate) |-> loc_flags[2]); // R9

    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_sts) |-> loc_flags[0]); // R10

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_wake_clr || loc_flags[0]) && (!irq_en_set || loc_flags[1])
        && (!irq_ps_chg || loc_flags[2])); // R12

endmodule

bind pm_ctrl_reg pm_ctrl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_wake_req (loc_wake_req),
    .wake_sts     (wake_sts),
    .wake_en      (wake_en),
    .cfg_rdata    (cfg_rdata),
    .loc_flags    (loc_flags),
    .loc_pstate   (loc_pstate),
    .wake_n       (wake_n),
    .irq_wake_clr (irq_wake_clr),
    .irq_en_set   (irq_en_set),
    .irq_ps_chg   (irq_ps_chg)
);

// File: tb/pm_ctrl_reg_test.sv
module pm_ctrl_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'hE0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        loc_wake_req = 1'b0;
    logic [2:0]  loc_flag_clr = 3'b0;
    logic        loc_ie_wr = 1'b0;
    logic [2:0]  loc_ie_wdata = 3'b0;
    logic [2:0]  loc_flags;
    logic [1:0]  loc_pstate;
    logic        wake_n;
    logic        irq_wake_clr;
    logic        irq_en_set;
    logic        irq_ps_chg;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pm_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .loc_wake_req(loc_wake_req), .loc_flag_clr(loc_flag_clr),
        .loc_ie_wr(loc_ie_wr), .loc_ie_wdata(loc_ie_wdata),
        .loc_flags(loc_flags), .loc_pstate(loc_pstate), .wake_n(wake_n),
        .irq_wake_clr(irq_wake_clr), .irq_en_set(irq_en_set),
        .irq_ps_chg(irq_ps_chg)
    );

    // Vectors {be, wdata, expected read word} from the state after reset.
    localparam logic [33:0] VEC [0:7] = '{
        {2'b11, 16'hFFFF, 16'h0103},  // R2 R3: reserved dropped, W1C no-op
        {2'b01, 16'h0001, 16'h0103},  // R4: D1 ignored
        {2'b01, 16'h0002, 16'h0103},  // R4: D2 ignored
        {2'b10, 16'h0000, 16'h0003},  // R3: upper byte only
        {2'b01, 16'h0000, 16'h0000},  // R4: back to D0
        {2'b00, 16'hFFFF, 16'h0000},  // R3: no byte enables
        {2'b10, 16'h0100, 16'h0100},  // R3
        {2'b01, 16'h00FF, 16'h0103}   // R2 R4: low byte, D3hot
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [1:0] be,
                           input logic [15:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = 8'hE0;
    endtask

    task automatic wake_req();
        @(negedge clk);
        loc_wake_req = 1'b1;
        @(negedge clk);
        loc_wake_req = 1'b0;
    endtask

    task automatic flag_clr(input logic [2:0] m);
        @(negedge clk);
        loc_flag_clr = m;
        @(negedge clk);
        loc_flag_clr = 3'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 word", cfg_rdata, 16'h0000);
        check("R1 flags/pstate", {11'b0, loc_flags, loc_pstate}, 16'h0);
        check("R1 wake/irq", {12'b0, wake_n, irq_wake_clr, irq_en_set, irq_ps_chg},
              16'h0008);

        for (int i = 0; i < 8; i++) begin
            host_wr(8'hE0, VEC[i][33:32], VEC[i][31:16]);
            check("R2/R3/R4 vector", cfg_rdata, VEC[i][15:0]);
        end
        check("R13 mirror D3hot", {14'b0, loc_pstate}, 16'h0003);
        check("R8/R9 flags latched", {13'b0, loc_flags}, 16'h0006);
        check("R12 irq masked", {13'b0, irq_wake_clr, irq_en_set, irq_ps_chg}, 16'h0);

        @(negedge clk);
        loc_ie_wr = 1'b1; loc_ie_wdata = 3'b111;
        @(negedge clk);
        loc_ie_wr = 1'b0;
        check("R12 irq enabled", {13'b0, irq_wake_clr, irq_en_set, irq_ps_chg}, 16'h0003);

        flag_clr(3'b110);
        check("R11 local clear", {13'b0, loc_flags}, 16'h0);

        host_wr(8'hE0, 2'b01, 16'h0003);
        host_wr(8'hE0, 2'b10, 16'h0100);
        check("R8/R9 redundant writes", {13'b0, loc_flags}, 16'h0);

        wake_req();
        check("R5 wake set", cfg_rdata, 16'h8103);
        check("R7 wake asserted", {15'b0, wake_n}, 16'h0);

        host_wr(8'hE0, 2'b10, 16'h0100);
        check("R5 zero no effect", cfg_rdata, 16'h8103);

        host_wr(8'hE0, 2'b10, 16'h8100);
        check("R5 host clear", cfg_rdata, 16'h0103);
        check("R7 wake released", {15'b0, wake_n}, 16'h1);
        check("R10 cleared flag", {13'b0, loc_flags}, 16'h0001);
        check("R12 wake-clr irq", {15'b0, irq_wake_clr}, 16'h1);

        flag_clr(3'b001);
        wake_req();
        // R6: host clear and local set in the same cycle
        @(negedge clk);
        cfg_addr = 8'hE0; cfg_be = 2'b10; cfg_wdata = 16'h8100;
        cfg_wr = 1'b1; loc_wake_req = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; loc_wake_req = 1'b0;
        check("R6 set wins", cfg_rdata, 16'h8103);
        check("R6 no clear flag", {13'b0, loc_flags}, 16'h0);

        host_wr(8'hE0, 2'b10, 16'h0000);
        check("R7 disabled", {15'b0, wake_n}, 16'h1);
        check("R5 status kept", cfg_rdata, 16'h8003);

        host_wr(8'hE0, 2'b10, 16'h0100);
        check("R7 re-enabled", {15'b0, wake_n}, 16'h0);
        check("R8 enable-set flag", {13'b0, loc_flags}, 16'h0002);

        host_wr(8'hE4, 2'b11, 16'h0000);
        @(negedge clk);
        cfg_addr = 8'hE4;
        #1;
        check("R2 foreign read", cfg_rdata, 16'h0);
        cfg_addr = 8'hE0;
        #1;
        check("R2 foreign write ignored", cfg_rdata, 16'h8103);

        // R11: local clear loses to a same-cycle set
        host_wr(8'hE0, 2'b10, 16'h0000);
        @(negedge clk);
        cfg_be = 2'b10; cfg_wdata = 16'h0100; cfg_wr = 1'b1;
        loc_flag_clr = 3'b010;
        @(negedge clk);
        cfg_wr = 1'b0; loc_flag_clr = 3'b0;
        check("R11 set beats clear", {13'b0, loc_flags}, 16'h0002);

        host_wr(8'hE0, 2'b01, 16'h0000);
        check("R13 mirror D0", {14'b0, loc_pstate}, 16'h0);
        check("R9 change flag", {13'b0, loc_flags}, 16'h0006);
        check("R12 ps irq", {15'b0, irq_ps_chg}, 16'h1);

        finish_run();
    end

endmodule